// File: doc/BRIEF.md
# Prioritized Interrupt Source Register with Maskable Request Line

This block gathers event pulses from several supervisory sub-blocks of a serially controlled supply and bus-transceiver device. The sources are supply under-voltage or regulator over-temperature, wake-up from stop mode, high-side driver over-temperature, bus fault or bus wake-up, supply over-voltage, and forced wake-up. Each pulse sets a sticky flag. A command decoder sees the block through two single-cycle strobes: a source read and a mask write. The write carries a 4-bit data field.

A read returns the 4-bit priority code of the highest pending flag and clears that one flag. Repeated reads therefore drain the pending sources one at a time, from highest priority to lowest. The active-low request line is low while an enabled flag is pending. After a read that cleared a flag, the line is held high for a fixed release interval before it may fall again. Three sources can be gated by the mask. Masking gates only the request line: the flag still latches and is still reported.

Top module: `isr_prio_top`

## Requirements
- R1: After reset all flags are clear, `rd_data_o` is 0000, `irq_n_o` is 1, and every mask bit is 1, so every source is enabled.
- R2: An event pulse sets its flag at the clock edge where it is sampled. If the source is enabled and no release interval is running, `irq_n_o` is 0 after that edge.
- R3: At the edge where `rd_i` or `wr_mask_i` is sampled, `rd_data_o` loads the code of the highest pending flag, whether masked or not, and holds it until the next strobe. The codes are: under-voltage/over-temperature 0001 (highest), stop wake-up 0010, high-side over-temperature 0011, bus fault/wake-up 0101, over-voltage 0110, forced wake-up 0111 (lowest). No flag pending gives 0000, and 0100 is never produced.
- R4: A read clears only the flag it reports, so successive reads return the pending codes in priority order.
- R5: After a read that reported a non-zero code, `irq_n_o` is 1 for exactly `HOLD_CYC` cycles, with `HOLD_CYC` = `CLK_KHZ*HOLD_US/1000`. It then returns to 0 if an enabled flag is still pending. If no enabled flag is pending, it stays at 1.
- R6: Mask bit 3 gates high-side over-temperature, bit 1 gates the bus source, and bit 0 gates over-voltage. A bit of 0 removes that source from the request line but leaves its flag latching and readable.
- R7: Under-voltage, stop wake-up and forced wake-up drive the request line whatever the mask holds.
- R8: A mask write returns the current code on `rd_data_o` exactly as a read does, but clears no flag and starts no release interval.
- R9: An event sampled in the same cycle as a read leaves its flag set afterwards. This holds both for a different source and for the source being read.
- R10: Setting the mask bit of a pending source pulls `irq_n_o` low right after the write edge, unless a release interval is running.
- R11: Mask bit 2 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| evt_lowvolt_i | input | 1 | Under-voltage / regulator over-temperature event pulse |
| evt_stopwake_i | input | 1 | Wake-up from stop mode event pulse |
| evt_hsot_i | input | 1 | High-side driver over-temperature event pulse |
| evt_bus_i | input | 1 | Bus fault or bus wake-up event pulse |
| evt_ovolt_i | input | 1 | Supply over-voltage event pulse |
| evt_forcewake_i | input | 1 | Forced wake-up event pulse |
| rd_i | input | 1 | Source read strobe (acknowledges the reported source) |
| wr_mask_i | input | 1 | Mask write strobe |
| wr_data_i | input | 4 | Mask value written with `wr_mask_i` |
| rd_data_o | output | 4 | Source code returned by the last read or mask write |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Directed sequences come first. One raises all six sources at once and drains them by reads, which shows whether the priority order and the per-read clearing are right. Another drains with the mask cleared, which separates the gated sources from the ungated ones. The directed cases also cover an event that coincides with a read of the same source and of a different source, a mask write while flags are pending, unmasking a pending source, and toggling the unused mask bit. A long random run then mixes sparse events, reads and mask writes. A bench model compares the returned code and the request line every cycle. That run catches release-interval reloads and events that arrive while the request line is held high.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int NSRC   = 6;
   localparam int CODE_W = 4;

   // Flag index equals priority rank (0 = highest).
   typedef enum int {
      SRC_LOWVOLT   = 0,
      SRC_STOPWAKE  = 1,
      SRC_HSOT      = 2,
      SRC_BUS       = 3,
      SRC_OVOLT     = 4,
      SRC_FORCEWAKE = 5
   } src_idx_e;

   // Code 0100 is skipped: ranks 0..2 map to 1..3, ranks 3..5 map to 5..7.
   function automatic logic [CODE_W-1:0] code_of(input int rank);
      int v;
      v = (rank < 3) ? rank + 1 : rank + 2;
      return v[CODE_W-1:0];
   endfunction
endpackage

// File: rtl/isr_flag_bank.sv
module isr_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   initial begin
      if (N < 1) $error("isr_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;   // a new event wins over an acknowledge
         else if (clr_i[i]) q <= 1'b0;
      end
      assign flag_o[i] = q;

      // R2
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_o[i]);
      // R4
      flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
   end
endmodule

// File: rtl/isr_prio_enc.sv
module isr_prio_enc
   import isr_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0]      req_i,
   output logic [N-1:0]      grant_o,
   output logic [CODE_W-1:0] code_o
);
   initial begin
      if (N > 7) $error("isr_prio_enc: code space holds at most 7 sources");
   end

   always_comb begin
      grant_o = '0;
      code_o  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o = '0;
            grant_o[i] = 1'b1;
            code_o = code_of(i);
         end
      end
   end

   always_comb begin
      // R4
      onehot_grant_chk: assert ($onehot0(grant_o));
      // R3
      grant_req_chk: assert ((grant_o & ~req_i) == '0);
   end
endmodule

// File: rtl/isr_irq_pacer.sv
module isr_irq_pacer #(
   parameter int HOLD_CYC = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   input  logic req_i,
   output logic irq_n_o
);
   localparam int CNT_W = $clog2(HOLD_CYC + 1);

   initial begin
      if (HOLD_CYC < 1) $error("isr_irq_pacer: HOLD_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (ack_i)        cnt_q <= CNT_W'(HOLD_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign irq_n_o = !(req_i && (cnt_q == '0));

   // R5
   hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> (cnt_q == CNT_W'(HOLD_CYC)));
endmodule

// File: rtl/isr_prio_top.sv
module isr_prio_top
   import isr_pkg::*;
#(
   parameter int CLK_KHZ = 250_000,
   parameter int HOLD_US = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_lowvolt_i,
   input  logic              evt_stopwake_i,
   input  logic              evt_hsot_i,
   input  logic              evt_bus_i,
   input  logic              evt_ovolt_i,
   input  logic              evt_forcewake_i,
   input  logic              rd_i,
   input  logic              wr_mask_i,
   input  logic [CODE_W-1:0] wr_data_i,
   output logic [CODE_W-1:0] rd_data_o,
   output logic              irq_n_o
);
   localparam int HOLD_CYC = (CLK_KHZ / 1000) * HOLD_US;

   initial begin
      if (HOLD_CYC < 1)  $error("isr_prio_top: release interval below one cycle");
      if (CODE_W != 4)   $error("isr_prio_top: code width must be 4");
   end

   logic [NSRC-1:0]   evt, flags, en, req, grant, clr;
   logic [CODE_W-1:0] code;
   logic              m_hs_q, m_bus_q, m_ov_q;
   logic              ack;
   logic              unused_c2;

   assign evt[SRC_LOWVOLT]   = evt_lowvolt_i;
   assign evt[SRC_STOPWAKE]  = evt_stopwake_i;
   assign evt[SRC_HSOT]      = evt_hsot_i;
   assign evt[SRC_BUS]       = evt_bus_i;
   assign evt[SRC_OVOLT]     = evt_ovolt_i;
   assign evt[SRC_FORCEWAKE] = evt_forcewake_i;

   assign unused_c2 = wr_data_i[2];

   // Mask bits, reset to enabled. Bit 2 is not stored.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hs_q  <= 1'b1;
         m_bus_q <= 1'b1;
         m_ov_q  <= 1'b1;
      end else if (wr_mask_i) begin
         m_hs_q  <= wr_data_i[3];
         m_bus_q <= wr_data_i[1];
         m_ov_q  <= wr_data_i[0];
      end
   end

   assign en[SRC_LOWVOLT]   = 1'b1;
   assign en[SRC_STOPWAKE]  = 1'b1;
   assign en[SRC_HSOT]      = m_hs_q;
   assign en[SRC_BUS]       = m_bus_q;
   assign en[SRC_OVOLT]     = m_ov_q;
   assign en[SRC_FORCEWAKE] = 1'b1;

   isr_flag_bank #(.N(NSRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt),
      .clr_i  (clr),
      .flag_o (flags)
   );

   isr_prio_enc #(.N(NSRC)) u_enc (
      .req_i   (flags),
      .grant_o (grant),
      .code_o  (code)
   );

   assign clr = grant & {NSRC{rd_i}};
   assign ack = rd_i && (flags != '0);
   assign req = flags & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rd_data_o <= '0;
      else if (rd_i || wr_mask_i) rd_data_o <= code;
   end

   isr_irq_pacer #(.HOLD_CYC(HOLD_CYC)) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_i   (ack),
      .req_i   (|req),
      .irq_n_o (irq_n_o)
   );

   // R3
   rd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i || wr_mask_i) |=> (rd_data_o == $past(code)));
   // R5
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> irq_n_o);
   // R6
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & en) == '0) |-> irq_n_o);
   // R8
   wr_noclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask_i && !rd_i) |=> (flags == ($past(flags) | $past(evt))));
   // R9
   evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (evt != '0)) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: tb/isr_prio_top_bench.sv
module isr_prio_top_bench;
   localparam int CLK_KHZ = 250_000;
   localparam int HOLD_US = 1;
   localparam int H = (CLK_KHZ / 1000) * HOLD_US;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt = '0;
   logic       rd = 1'b0, wr = 1'b0;
   logic [3:0] wdata = '0;
   logic [3:0] rd_data;
   logic       irq_n;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   string tag = "R1";

   // model state
   logic [5:0] m_flags = '0;
   logic [3:0] m_mask = 4'hF;
   logic [3:0] m_rd = '0;
   int         m_hold = 0;

   always #2 clk = ~clk;

   isr_prio_top #(.CLK_KHZ(CLK_KHZ), .HOLD_US(HOLD_US)) u_isr_prio_top (
      .clk(clk), .rst_n(rst_n),
      .evt_lowvolt_i(evt[0]), .evt_stopwake_i(evt[1]), .evt_hsot_i(evt[2]),
      .evt_bus_i(evt[3]), .evt_ovolt_i(evt[4]), .evt_forcewake_i(evt[5]),
      .rd_i(rd), .wr_mask_i(wr), .wr_data_i(wdata),
      .rd_data_o(rd_data), .irq_n_o(irq_n));

   function automatic int top_idx(input logic [5:0] f);
      for (int i = 0; i < 6; i++) if (f[i]) return i;
      return -1;
   endfunction

   function automatic logic [3:0] code_for(input int idx);
      if (idx < 0) return 4'd0;
      return (idx < 3) ? 4'(idx + 1) : 4'(idx + 2);
   endfunction

   function automatic logic [5:0] enables(input logic [3:0] m);
      return {1'b1, m[0], m[1], m[3], 1'b1, 1'b1};
   endfunction

   function automatic logic exp_irq_n();
      return !(((m_flags & enables(m_mask)) != '0) && m_hold == 0);
   endfunction

   task automatic check(input string what, input logic [3:0] act, input logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic cycle(input logic [5:0] e, input logic r, input logic w, input logic [3:0] d);
      int idx;
      evt = e; rd = r; wr = w; wdata = d;
      @(posedge clk);
      idx = top_idx(m_flags);
      if (r || w) m_rd = code_for(idx);
      if (r && idx >= 0) begin
         m_flags[idx] = 1'b0;
         m_hold = H;
      end else if (m_hold > 0) m_hold--;
      m_flags = m_flags | e;
      if (w) m_mask = d;
      @(negedge clk);
      evt = '0; rd = 0; wr = 0;
      check("rd_data", rd_data, m_rd);
      check("irq_n", {3'b0, irq_n}, {3'b0, exp_irq_n()});
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cycle('0, 0, 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 reset state
      tag = "R1";
      check("rd_data reset", rd_data, 4'd0);
      check("irq_n reset", {3'b0, irq_n}, 4'd1);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R6: mask resets enabled -> gated source raises the line
      tag = "R1 mask reset enabled";
      cycle(6'b000100, 0, 0, '0);
      check("irq low hs", {3'b0, irq_n}, 4'd0);
      // R4/R5: drain hs, then hold with none pending
      tag = "R5 lone ack";
      cycle('0, 1, 0, '0);
      check("code hs", rd_data, 4'b0011);
      idle(H + 3);
      // R3/R4/R5: all six pending, drained in order
      tag = "R3 R4 R5 drain order";
      cycle(6'b111111, 0, 0, '0);
      for (int k = 0; k < 6; k++) begin
         cycle('0, 1, 0, '0);
         check("order", rd_data, code_for(k));
         idle(H + 1);
      end
      tag = "R3 empty read";
      cycle('0, 1, 0, '0);
      check("empty", rd_data, 4'd0);
      // R6/R7: mask all, gated ones do not raise, ungated do
      tag = "R6 gated flags latch";
      cycle('0, 0, 1, 4'b0000);
      cycle(6'b011100, 0, 0, '0);
      check("irq gated", {3'b0, irq_n}, 4'd1);
      tag = "R8 mask write returns code";
      cycle('0, 0, 1, 4'b0000);
      check("wr code", rd_data, 4'b0011);
      cycle('0, 0, 1, 4'b0000);
      check("wr no clear", rd_data, 4'b0011);
      tag = "R11 bit2 no effect";
      cycle('0, 0, 1, 4'b0100);
      check("irq bit2", {3'b0, irq_n}, 4'd1);
      tag = "R10 unmask pending";
      cycle('0, 0, 1, 4'b0001);
      check("irq unmask ov", {3'b0, irq_n}, 4'd0);
      cycle('0, 0, 1, 4'b0000);
      tag = "R7 ungated under mask";
      cycle(6'b100011, 0, 0, '0);
      check("irq ungated", {3'b0, irq_n}, 4'd0);
      // R9: event on other source and on same source during read
      tag = "R9 coincident events";
      cycle(6'b000001, 1, 0, '0);
      check("same src kept", rd_data, 4'b0001);
      cycle('0, 1, 0, '0);
      check("reread lowvolt", rd_data, 4'b0001);
      cycle(6'b001000, 1, 0, '0);
      idle(H + 2);
      for (int k = 0; k < 8; k++) cycle('0, 1, 0, '0);
      cycle('0, 0, 1, 4'b1111);
      idle(H + 2);
      // random phase
      tag = "R2 R3 R4 R5 R6 random";
      for (int k = 0; k < 6000; k++) begin
         logic [5:0] e;
         for (int b = 0; b < 6; b++) e[b] = ($urandom % 24) == 0;
         cycle(e, ($urandom % 10) == 0, ($urandom % 40) == 0, 4'($urandom));
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule